// File: doc/BRIEF.md
# Edge-Latched Interrupt Event and Mask Controller

This block collects interrupt requests into a 31-bit sticky event register and reduces them to one level-sensitive interrupt line. Hardware sources raise an event on a rising edge. Software raises an event by writing ones to a set address, and lowers one by writing ones to a separate clear address. Because zeros are ignored at both addresses, several agents can update different bits without a read-modify-write sequence.

A 32-bit mask register uses the same set/clear scheme. Its top bit is a global gate, and each lower bit enables the event in the same position. A small error-report register is folded into event bit 30. Hardware error inputs and software writes set its bits, and writes of one to a separate address clear them. While any error bit is set, event bit 30 cannot be cleared.

The register port has a write strobe, a 3-bit register address, write data and read data. Reads are combinational and follow the address directly.

Top module: `irq_evt_top`

## Requirements
- R1: After reset the event, mask and error-report registers all read 0 and `irqOut` is 0.
- R2: A 0-to-1 change on `srcIn[i]` between two consecutive clock samples sets event bit i. A source held high does not set the bit again after it has been cleared.
- R3: A write to address 0 sets each event bit whose data bit is 1. Data bits of 0 leave event bits unchanged.
- R4: A write to address 1 clears each event bit whose data bit is 1. Data bits of 0 leave event bits unchanged. Event bits change from 1 to 0 in no other way.
- R5: When a source edge and a clear write for the same event bit fall in the same cycle, the bit ends up set.
- R6: A write to address 2 sets mask bits and a write to address 3 clears mask bits, each under write-1 rules. A read at either address returns the full 32-bit mask. The mask changes only on such writes.
- R7: A read at address 0 or 1 returns the event register in bits 30:0, with bit 31 reading 0.
- R8: `irqOut` is 1 exactly when mask bit 31 is 1 and at least one of event bits 30:0 is 1 where the mask bit in the same position is also 1.
- R9: Event bit 30 is set in the cycle after any error-report bit is 1. A clear write to bit 30 has no effect while an error-report bit is set, and takes effect once none is set.
- R10: An error-report bit is set by a high level on `errIn` or by a write of 1 at address 4. It is cleared by a write of 1 at address 5, and a set in the same cycle wins over the clear. A read at address 4 or 5 returns the register in the low bits, with zeros above.
- R11: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register address for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` |
| srcIn | input | 30 | Interrupt sources for event bits 29:0 |
| errIn | input | 8 | Error flags that set error-report bits |
| irqOut | output | 1 | Level interrupt request |

## Verification
Two pairs of actions can land on the same clock edge and contend for one bit. The first pair is a rising source edge and a software clear of that event bit. The bench raises `srcIn[5]` on the same cycle as a write of 1 at address 1 to that bit, and expects the bit to read back as set. The second pair is a high `errIn` bit and a clear write at address 5 to the same bit, which must also leave the bit set. A behavioural model updated on every clock predicts read data and `irqOut`, so the bench also checks what happens to event bit 30 while an error clear and the summary update overlap.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int ADDR_W = 3;

  // register port address map
  localparam logic [ADDR_W-1:0] A_EVT_SET = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVT_CLR = 3'd1;
  localparam logic [ADDR_W-1:0] A_MSK_SET = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSK_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] A_ERR_SET = 3'd4;
  localparam logic [ADDR_W-1:0] A_ERR_CLR = 3'd5;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_EVT  = 2'd1,
    RD_MSK  = 2'd2,
    RD_ERR  = 2'd3
  } rd_sel_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic evtSet;
    logic evtClr;
    logic mskSet;
    logic mskClr;
    logic errSet;
    logic errClr;
  } wr_strobe_t;

endpackage

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wr_strobe_t        strobe,
  output rd_sel_e           rdSel
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (regAddr)
        A_EVT_SET: strobe.evtSet = 1'b1;
        A_EVT_CLR: strobe.evtClr = 1'b1;
        A_MSK_SET: strobe.mskSet = 1'b1;
        A_MSK_CLR: strobe.mskClr = 1'b1;
        A_ERR_SET: strobe.errSet = 1'b1;
        A_ERR_CLR: strobe.errClr = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      A_EVT_SET, A_EVT_CLR: rdSel = RD_EVT;
      A_MSK_SET, A_MSK_CLR: rdSel = RD_MSK;
      A_ERR_SET, A_ERR_CLR: rdSel = RD_ERR;
      default:              rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/irq_evt_dp.sv
module irq_evt_dp
  import irq_evt_pkg::*;
#(
  parameter int EVT_W = 32,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wr_strobe_t       strobe,
  input  rd_sel_e          rdSel,
  input  logic [EVT_W-1:0] wrData,
  input  logic [EVT_W-3:0] srcIn,
  input  logic [ERR_W-1:0] errIn,
  output logic [EVT_W-2:0] evtQ,
  output logic [EVT_W-1:0] maskQ,
  output logic [ERR_W-1:0] errQ,
  output logic [EVT_W-1:0] rdData
);

  localparam int SRC_W  = EVT_W - 2;
  localparam int EVTR_W = EVT_W - 1;

  logic [SRC_W-1:0]  srcPrev;
  logic [SRC_W-1:0]  srcEdge;
  logic [EVTR_W-1:0] hwSet;
  logic [EVTR_W-1:0] swSet;
  logic [EVTR_W-1:0] swClr;
  logic [EVTR_W-1:0] evtNext;
  logic [EVT_W-1:0]  maskNext;
  logic [ERR_W-1:0]  errNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= srcIn;
  end

  assign srcEdge = srcIn & ~srcPrev;
  assign hwSet   = {|errQ, srcEdge};
  assign swSet   = strobe.evtSet ? wrData[EVTR_W-1:0] : '0;
  assign swClr   = strobe.evtClr ? wrData[EVTR_W-1:0] : '0;

  // sets take priority over a clear in the same cycle
  assign evtNext = (evtQ & ~swClr) | swSet | hwSet;

  always_comb begin
    maskNext = maskQ;
    if (strobe.mskSet) maskNext = maskQ | wrData;
    if (strobe.mskClr) maskNext = maskQ & ~wrData;
  end

  always_comb begin
    errNext = errQ;
    if (strobe.errClr) errNext = errNext & ~wrData[ERR_W-1:0];
    if (strobe.errSet) errNext = errNext | wrData[ERR_W-1:0];
    errNext = errNext | errIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= '0;
      errQ  <= '0;
    end else begin
      evtQ  <= evtNext;
      maskQ <= maskNext;
      errQ  <= errNext;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_EVT:  rdData[EVTR_W-1:0] = evtQ;
      RD_MSK:  rdData = maskQ;
      RD_ERR:  rdData[ERR_W-1:0] = errQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_evt_top.sv
module irq_evt_top
  import irq_evt_pkg::*;
#(
  parameter int EVT_W = 32,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_W-1:0]  wrData,
  output logic [EVT_W-1:0]  rdData,
  input  logic [EVT_W-3:0]  srcIn,
  input  logic [ERR_W-1:0]  errIn,
  output logic              irqOut
);

  localparam int MASTER_BIT = EVT_W - 1;

  wr_strobe_t       strobe;
  rd_sel_e          rdSel;
  logic [EVT_W-2:0] evtQ;
  logic [EVT_W-1:0] maskQ;
  logic [ERR_W-1:0] errQ;

  irq_evt_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irq_evt_dp #(.EVT_W(EVT_W), .ERR_W(ERR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (wrData),
    .srcIn  (srcIn),
    .errIn  (errIn),
    .evtQ   (evtQ),
    .maskQ  (maskQ),
    .errQ   (errQ),
    .rdData (rdData)
  );

  assign irqOut = maskQ[MASTER_BIT] & (|(evtQ & maskQ[EVT_W-2:0]));

endmodule

// File: rtl/irq_evt_chk.sv
module irq_evt_chk
  import irq_evt_pkg::*;
#(
  parameter int EVT_W = 32,
  parameter int ERR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [EVT_W-3:0]  srcIn,
  input logic [EVT_W-2:0]  evtQ,
  input logic [EVT_W-1:0]  maskQ,
  input logic [ERR_W-1:0]  errQ,
  input logic              irqOut
);

  localparam int SRC_W = EVT_W - 2;

  logic [1:0] cycCnt;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cycCnt <= '0;
    else if (cycCnt != 2'd3) cycCnt <= cycCnt + 2'd1;
  end
  assign armed = (cycCnt >= 2'd2);

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (($past(srcIn) & ~$past(srcIn, 2) & ~evtQ[SRC_W-1:0]) == '0)); // R2

  AST_EVT_CLR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (|($past(evtQ) & ~evtQ))) |->
      ($past(wrEn) && ($past(regAddr) == A_EVT_CLR))); // R4

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && ((regAddr == A_MSK_SET) || (regAddr == A_MSK_CLR))) |=> $stable(maskQ)); // R6

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[EVT_W-1] |-> !irqOut); // R8

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (|errQ) |=> evtQ[EVT_W-2]); // R9

endmodule

bind irq_evt_top irq_evt_chk #(.EVT_W(EVT_W), .ERR_W(ERR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .regAddr (regAddr),
  .srcIn   (srcIn),
  .evtQ    (evtQ),
  .maskQ   (maskQ),
  .errQ    (errQ),
  .irqOut  (irqOut)
);

// File: tb/test_irq_evt_top.sv
module test_irq_evt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [29:0] srcIn = '0;
  logic [7:0]  errIn = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit [30:0] mEvt = '0;
  bit [31:0] mMsk = '0;
  bit [7:0]  mErr = '0;
  bit [29:0] mPrev = '0;
  bit [29:0] srcV = '0;
  bit [7:0]  errV = '0;

  always #10 clk = ~clk;

  irq_evt_top i_irq_evt_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .errIn(errIn), .irqOut(irqOut)
  );

  function automatic bit [31:0] mRead(input int a);
    case (a)
      0, 1:    return {1'b0, mEvt};
      2, 3:    return mMsk;
      4, 5:    return {24'd0, mErr};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit mIrq();
    bit any = 0;
    for (int i = 0; i < 31; i++) if (mEvt[i] && mMsk[i]) any = 1;
    return mMsk[31] && any;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input int a, input bit [31:0] d,
                     input bit ckR, input bit [31:0] expR,
                     input bit ckI, input bit expI, input string tag);
    @(negedge clk);
    wrEn = w; regAddr = a[2:0]; wrData = d; srcIn = srcV; errIn = errV;
    #1;
    chk("R7 model read", rdData, mRead(a));
    chk("R8 model irq", {31'd0, irqOut}, {31'd0, mIrq()});
    if (ckR) chk(tag, rdData, expR);
    if (ckI) chk(tag, {31'd0, irqOut}, {31'd0, expI});
    @(posedge clk);
    begin
      bit [30:0] nEvt;
      bit [7:0]  nErr;
      nEvt = mEvt;
      for (int i = 0; i < 31; i++) begin
        if (w && a == 1 && d[i]) nEvt[i] = 0;
        if (w && a == 0 && d[i]) nEvt[i] = 1;
        if (i < 30 && srcV[i] && !mPrev[i]) nEvt[i] = 1;
        if (i == 30 && mErr != 0) nEvt[i] = 1;
      end
      nErr = mErr;
      for (int i = 0; i < 8; i++) begin
        if (w && a == 5 && d[i]) nErr[i] = 0;
        if ((w && a == 4 && d[i]) || errV[i]) nErr[i] = 1;
      end
      if (w && a == 2) mMsk = mMsk | d;
      if (w && a == 3) mMsk = mMsk & ~d;
      mEvt = nEvt; mErr = nErr; mPrev = srcV;
    end
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, "");
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic peek(input int a, input bit [31:0] e, input string tag);
    cyc(0, a, 0, 1, e, 0, 0, tag);
  endtask
  task automatic peekIrq(input bit e, input string tag);
    cyc(0, 0, 0, 0, 0, 1, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", {31'd0, irqOut}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    peek(0, 32'h0, "R1 event after reset");
    peek(2, 32'h0, "R1 mask after reset");
    peek(4, 32'h0, "R1 error after reset");
    peekIrq(0, "R1 irq after reset");

    // R2 edge detection
    srcV[3] = 1; idle();
    peek(0, 32'h8, "R2 edge sets bit3");
    wr(1, 32'h8);
    peek(0, 32'h0, "R2 held source no reset");
    srcV[3] = 0; idle();
    srcV[3] = 1; idle();
    peek(0, 32'h8, "R2 second edge");

    // R3 set address
    wr(0, 32'h101);
    peek(0, 32'h109, "R3 write-1 set");
    wr(0, 32'h0);
    peek(1, 32'h109, "R3 zero no effect");

    // R4 clear address
    wr(1, 32'h1);
    peek(0, 32'h108, "R4 write-1 clear");
    wr(1, 32'h0);
    peek(0, 32'h108, "R4 zero no effect");

    // R5 edge and clear in same cycle
    srcV[5] = 1; wr(1, 32'h20);
    peek(0, 32'h128, "R5 edge beats clear");
    wr(1, 32'h7FFF_FFFF);
    peek(0, 32'h0, "R4 clear all");

    // R6 / R8 mask and interrupt
    wr(2, 32'h8000_0004);
    peek(2, 32'h8000_0004, "R6 mask read at set");
    peek(3, 32'h8000_0004, "R6 mask read at clear");
    peekIrq(0, "R8 no event no irq");
    wr(0, 32'h4);
    peekIrq(1, "R8 enabled event irq");
    wr(3, 32'h8000_0000);
    peekIrq(0, "R8 master off");
    peek(2, 32'h4, "R6 clear master only");
    wr(2, 32'h8000_0000);
    peekIrq(1, "R8 master on again");
    wr(3, 32'h4);
    peekIrq(0, "R8 bit mask off");
    peek(3, 32'h8000_0000, "R6 mask after clear");

    // R7 bit 31 of event reads 0
    wr(0, 32'hFFFF_FFFF);
    peek(1, 32'h7FFF_FFFF, "R7 event bit31 zero");
    wr(1, 32'hFFFF_FFFF);
    peek(0, 32'h0, "R4 clear everything");

    // R9 / R10 error summary
    errV = 8'h02; idle(); errV = 8'h00;
    peek(4, 32'h2, "R10 errIn sets bit");
    peek(0, 32'h4000_0000, "R9 summary set");
    wr(1, 32'h4000_0000);
    peek(0, 32'h4000_0000, "R9 clear blocked by error");
    wr(5, 32'h2);
    peek(4, 32'h0, "R10 write-1 clear");
    wr(1, 32'h4000_0000);
    peek(0, 32'h0, "R9 clear after errors gone");

    wr(4, 32'h81);
    peek(5, 32'h81, "R10 software set");
    wr(5, 32'h1);
    peek(4, 32'h80, "R10 partial clear");
    errV = 8'h01; wr(5, 32'h1); errV = 8'h00;
    peek(4, 32'h81, "R10 set beats clear");
    wr(5, 32'hFF);
    wr(1, 32'h7FFF_FFFF);
    peek(0, 32'h0, "R9 all clear");

    // R11 unused addresses
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    peek(6, 32'h0, "R11 addr6 reads zero");
    peek(7, 32'h0, "R11 addr7 reads zero");
    peek(0, 32'h0, "R11 events untouched");
    peek(2, 32'h8000_0000, "R11 mask untouched");
    peek(4, 32'h0, "R11 errors untouched");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule